// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is a single input port driven by an external producer through a strobe handshake. The producer places a byte on the port pins and pulses a strobe line. On the strobe's rising transition the port stores the byte and raises a buffer-full flag. If its interrupt-enable flag is set, it also raises an interrupt request. The host collects the byte through a one-cycle read interface. That read drops both the flag and the request.

The interrupt-enable flag has no pin of its own. The host sets or clears it with a single-bit set/reset command aimed at one control-line position. That position is 4 when the block is built as the first port and 2 when it is built as the second. The same command reaches two spare control lines at positions 7 and 6, which the block drives as general-purpose outputs. A status read returns the flags and spare lines and leaves them unchanged. The strobe pin is asynchronous and passes through a synchronizer before its edge is detected.

Top module: `strbInPort`

## Requirements
- R1: After reset, bufFull, intReq, spareOut, the interrupt-enable flag and the stored byte are all 0. A status read and a port read both return 0.
- R2: The byte on portData is stored when the strobe rises. The strobe is seen after SYNC_STAGES+1 clock edges, and the data must be held while the strobe is high. A falling strobe or a steady level stores nothing.
- R3: A stored byte sets bufFull. bufFull stays 1 until a port read.
- R4: A port read (rdEn=1, rdSel=0) returns the stored byte on rdData in the same cycle. On the next edge it clears bufFull and intReq. The stored byte itself is kept.
- R5: A status read (rdEn=1, rdSel=1) changes nothing. It returns bit0 bufFull, bit1 intReq, bit2 interrupt enable, bit3 spareOut[0] and bit4 spareOut[1], with the upper bits 0. rdData is 0 when rdEn=0.
- R6: A capture raises intReq only if interrupt enable is 1 at that moment. Setting interrupt enable while a byte is already waiting does not raise intReq.
- R7: A command (cmdValid=1) with cmdBit equal to 4 (PORT_B=0) or 2 (PORT_B=1) loads interrupt enable from cmdSet. Clearing the enable drops intReq.
- R8: A command with cmdBit 7 loads spareOut[1] from cmdSet. A command with cmdBit 6 loads spareOut[0] from cmdSet.
- R9: A command at any other cmdBit changes neither the interrupt enable nor the spare lines.
- R10: A strobe that arrives while bufFull is 1 replaces the stored byte, and bufFull stays 1.
- R11: If a capture and a port read fall on the same edge, the capture wins. The new byte is stored, bufFull stays 1 and intReq follows interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stbIn | input | 1 | Asynchronous strobe from the producer; captures on its rising transition |
| portData | input | DATA_W | Byte presented by the producer |
| rdEn | input | 1 | Host read request for one cycle |
| rdSel | input | 1 | Read target: 0 = stored byte (clears flags), 1 = status |
| rdData | output | DATA_W | Read data, valid while rdEn is 1 |
| cmdValid | input | 1 | Bit set/reset command strobe |
| cmdBit | input | 3 | Control-line position addressed by the command |
| cmdSet | input | 1 | Value written by the command |
| bufFull | output | 1 | Unread byte waiting |
| intReq | output | 1 | Interrupt request |
| spareOut | output | 2 | General-purpose lines (positions 6 and 7) |

## Verification
The bench builds two copies of the block side by side, one with PORT_B=0 and one with PORT_B=1. Both use DATA_W=8 and SYNC_STAGES=2, and both see the same stimulus. Every enable command therefore lands on exactly one of the two copies, which shows that the enable position follows the parameter. It also shows that the other copy's enable position is ignored. With the two-stage synchronizer the capture edge can be placed exactly, so a port read can be made to coincide with a capture.

// File: rtl/strb_in_pkg.sv
package strb_in_pkg;
  typedef struct packed {
    logic capture;     // strobe rising edge seen after synchronizer
    logic portRead;    // host reads the stored byte
    logic ieWrite;     // command addresses the interrupt-enable position
    logic ieVal;
    logic spareWrite;  // command addresses a spare line
    logic spareIdx;    // 0 = lower spare, 1 = upper spare
    logic spareVal;
  } ctrlStrobes_t;
endpackage

// File: rtl/strbInCtrl.sv
module strbInCtrl
  import strb_in_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IE_BIT      = 4,
  parameter int SPARE_LO    = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         stbIn,
  input  logic         rdEn,
  input  logic         rdSel,
  input  logic         cmdValid,
  input  logic [2:0]   cmdBit,
  input  logic         cmdSet,
  output ctrlStrobes_t strobes,
  output logic         bufFull,
  output logic         intReq,
  output logic         intEn
);
  localparam logic [2:0] IE_IDX    = IE_BIT[2:0];
  localparam logic [2:0] SPLO_IDX  = SPARE_LO[2:0];
  localparam logic [2:0] SPHI_IDX  = SPLO_IDX + 3'd1;
  localparam int         LAST      = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   stbPrevQ;
  logic                   ieNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      stbPrevQ <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], stbIn};
      stbPrevQ <= syncQ[LAST];
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.capture    = syncQ[LAST] & ~stbPrevQ;
    strobes.portRead   = rdEn & ~rdSel;
    strobes.ieWrite    = cmdValid && (cmdBit == IE_IDX);
    strobes.ieVal      = cmdSet;
    strobes.spareWrite = cmdValid && ((cmdBit == SPLO_IDX) || (cmdBit == SPHI_IDX));
    strobes.spareIdx   = (cmdBit == SPHI_IDX);
    strobes.spareVal   = cmdSet;
  end

  assign ieNext = strobes.ieWrite ? strobes.ieVal : intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      intReq  <= 1'b0;
      intEn   <= 1'b0;
    end else begin
      intEn <= ieNext;
      if (strobes.capture) begin
        bufFull <= 1'b1;
        intReq  <= ieNext;
      end else begin
        if (strobes.portRead) bufFull <= 1'b0;
        if (strobes.portRead || !ieNext) intReq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/strbInData.sv
module strbInData
  import strb_in_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] portData,
  input  logic              rdEn,
  input  logic              rdSel,
  input  logic              bufFull,
  input  logic              intReq,
  input  logic              intEn,
  output logic [DATA_W-1:0] latchQ,
  output logic [1:0]        spareOut,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                latchQ <= '0;
    else if (strobes.capture) latchQ <= portData;
  end

  for (genvar i = 0; i < 2; i++) begin : g_spare
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        spareOut[i] <= 1'b0;
      else if (strobes.spareWrite && (strobes.spareIdx == (i == 1)))
        spareOut[i] <= strobes.spareVal;
    end
  end

  always_comb begin
    statusWord      = '0;
    statusWord[4:0] = {spareOut[1], spareOut[0], intEn, intReq, bufFull};
  end

  assign rdData = !rdEn ? '0 : (rdSel ? statusWord : latchQ);
endmodule

// File: rtl/strbInPort.sv
module strbInPort
  import strb_in_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PORT_B      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stbIn,
  input  logic [DATA_W-1:0] portData,
  input  logic              rdEn,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              cmdValid,
  input  logic [2:0]        cmdBit,
  input  logic              cmdSet,
  output logic              bufFull,
  output logic              intReq,
  output logic [1:0]        spareOut
);
  localparam int IE_BIT   = (PORT_B != 0) ? 2 : 4;
  localparam int SPARE_LO = 6;

  ctrlStrobes_t      ctlStrobes;
  logic              intEnQ;
  logic [DATA_W-1:0] latchQ;

  strbInCtrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .IE_BIT     (IE_BIT),
    .SPARE_LO   (SPARE_LO)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stbIn   (stbIn),
    .rdEn    (rdEn),
    .rdSel   (rdSel),
    .cmdValid(cmdValid),
    .cmdBit  (cmdBit),
    .cmdSet  (cmdSet),
    .strobes (ctlStrobes),
    .bufFull (bufFull),
    .intReq  (intReq),
    .intEn   (intEnQ)
  );

  strbInData #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (ctlStrobes),
    .portData(portData),
    .rdEn    (rdEn),
    .rdSel   (rdSel),
    .bufFull (bufFull),
    .intReq  (intReq),
    .intEn   (intEnQ),
    .latchQ  (latchQ),
    .spareOut(spareOut),
    .rdData  (rdData)
  );
endmodule

// File: rtl/strbInPort_chk.sv
module strbInPort_chk #(
  parameter int DATA_W = 8,
  parameter int PORT_B = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              rdSel,
  input logic              cmdValid,
  input logic [2:0]        cmdBit,
  input logic              cmdSet,
  input logic              bufFull,
  input logic              intReq,
  input logic [1:0]        spareOut,
  input logic [DATA_W-1:0] portData,
  input logic              capEvt,
  input logic              intEn,
  input logic [DATA_W-1:0] latchQ
);
  localparam logic [2:0] IE_IDX = (PORT_B != 0) ? 3'd2 : 3'd4;

  logic portRd;
  assign portRd = rdEn && !rdSel;

  p_cap_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    capEvt |=> latchQ == $past(portData));

  p_cap_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    capEvt |=> bufFull);

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !portRd) |=> bufFull);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && !capEvt) |=> (!bufFull && !intReq));

  p_read_keeps_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    !capEvt |=> $stable(latchQ));

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (bufFull && intEn));

  p_ie_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdBit == IE_IDX) |=> intEn == $past(cmdSet));

  p_spare_hi_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdBit == 3'd7) |=> spareOut[1] == $past(cmdSet));

  p_ie_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdBit == IE_IDX) |=> $stable(intEn));

  p_spare_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdBit[2:1] == 2'b11) |=> $stable(spareOut));
endmodule

bind strbInPort strbInPort_chk #(.DATA_W(DATA_W), .PORT_B(PORT_B)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdEn    (rdEn),
  .rdSel   (rdSel),
  .cmdValid(cmdValid),
  .cmdBit  (cmdBit),
  .cmdSet  (cmdSet),
  .bufFull (bufFull),
  .intReq  (intReq),
  .spareOut(spareOut),
  .portData(portData),
  .capEvt  (ctlStrobes.capture),
  .intEn   (intEnQ),
  .latchQ  (latchQ)
);

// File: tb/sim_strbInPort.sv
`timescale 1ns/1ps
module sim_strbInPort;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stbIn = 1'b0;
  logic [DW-1:0] portData = '0;
  logic          rdEn = 1'b0, rdSel = 1'b0;
  logic          cmdValid = 1'b0, cmdSet = 1'b0;
  logic [2:0]    cmdBit = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic          fullA, fullB, irqA, irqB;
  logic [1:0]    spA, spB;

  int total = 0;
  int fails = 0;

  // bench model
  logic [DW-1:0] mByte = '0;
  logic          mFull = 0, mIeA = 0, mIeB = 0, mIrqA = 0, mIrqB = 0;
  logic [1:0]    mSpare = '0;

  always #2 clk = ~clk;  // 250 MHz

  strbInPort #(.DATA_W(DW), .SYNC_STAGES(2), .PORT_B(0)) u0 (
    .clk(clk), .rstN(rstN), .stbIn(stbIn), .portData(portData),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdDataA), .cmdValid(cmdValid),
    .cmdBit(cmdBit), .cmdSet(cmdSet), .bufFull(fullA), .intReq(irqA),
    .spareOut(spA));

  strbInPort #(.DATA_W(DW), .SYNC_STAGES(2), .PORT_B(1)) u1 (
    .clk(clk), .rstN(rstN), .stbIn(stbIn), .portData(portData),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdDataB), .cmdValid(cmdValid),
    .cmdBit(cmdBit), .cmdSet(cmdSet), .bufFull(fullB), .intReq(irqB),
    .spareOut(spB));

  function automatic logic [DW-1:0] expStatus(logic full, logic irq, logic ie,
                                               logic [1:0] sp);
    logic [DW-1:0] w;
    w = '0;
    w[0] = full; w[1] = irq; w[2] = ie; w[3] = sp[0]; w[4] = sp[1];
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkPins(string req);
    chk({req, " bufFull u0"}, 32'(fullA), 32'(mFull));
    chk({req, " bufFull u1"}, 32'(fullB), 32'(mFull));
    chk({req, " intReq u0"}, 32'(irqA), 32'(mIrqA));
    chk({req, " intReq u1"}, 32'(irqB), 32'(mIrqB));
    chk({req, " spare u0"}, 32'(spA), 32'(mSpare));
    chk({req, " spare u1"}, 32'(spB), 32'(mSpare));
  endtask

  task automatic statusRead(string req);
    @(negedge clk); rdEn = 1; rdSel = 1; #1;
    chk({req, " R5 status u0"}, 32'(rdDataA), 32'(expStatus(mFull, mIrqA, mIeA, mSpare)));
    chk({req, " R5 status u1"}, 32'(rdDataB), 32'(expStatus(mFull, mIrqB, mIeB, mSpare)));
    @(negedge clk); rdEn = 0; rdSel = 0;
  endtask

  task automatic portRead(string req);
    @(negedge clk); rdEn = 1; rdSel = 0; #1;
    chk({req, " R4 byte u0"}, 32'(rdDataA), 32'(mByte));
    chk({req, " R4 byte u1"}, 32'(rdDataB), 32'(mByte));
    @(negedge clk); rdEn = 0;
    mFull = 0; mIrqA = 0; mIrqB = 0;
  endtask

  task automatic strobe(logic [DW-1:0] d);
    @(negedge clk); portData = d; stbIn = 1;
    repeat (4) @(negedge clk);
    stbIn = 0;
    repeat (4) @(negedge clk);
    mByte = d; mFull = 1; mIrqA = mIeA; mIrqB = mIeB;
  endtask

  task automatic command(logic [2:0] b, logic v);
    @(negedge clk); cmdValid = 1; cmdBit = b; cmdSet = v;
    @(negedge clk); cmdValid = 0;
    if (b == 3'd4) begin mIeA = v; if (!v) mIrqA = 0; end
    if (b == 3'd2) begin mIeB = v; if (!v) mIrqB = 0; end
    if (b == 3'd7) mSpare[1] = v;
    if (b == 3'd6) mSpare[0] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    checkPins("R1");
    statusRead("R1");
    portRead("R1");

    // R2/R3 capture, no interrupt since enable is clear (R6)
    strobe(8'hA5);
    checkPins("R2 R3 R6");
    statusRead("R5 no-clear");
    checkPins("R5 after status");

    // R2: data changed while high and after fall is not captured
    @(negedge clk); portData = 8'h3C; stbIn = 1;
    repeat (4) @(negedge clk); portData = 8'h77;
    repeat (2) @(negedge clk); stbIn = 0;
    repeat (2) @(negedge clk); portData = 8'h11;
    repeat (4) @(negedge clk);
    mByte = 8'h3C; mFull = 1;
    portRead("R2 R10 first-edge only");
    checkPins("R4 cleared");
    portRead("R4 byte kept");

    // R7: enable positions differ per build
    command(3'd4, 1);
    strobe(8'h5A);
    checkPins("R7 R6 u0 only");
    command(3'd2, 1);
    checkPins("R6 late enable no irq");
    command(3'd4, 0);
    checkPins("R7 clear drops irq");
    portRead("R4");
    command(3'd4, 1);

    // R8/R9 spare and ignored positions
    command(3'd7, 1);
    command(3'd6, 0);
    checkPins("R8");
    command(3'd6, 1);
    command(3'd0, 0);
    command(3'd1, 1);
    command(3'd3, 1);
    command(3'd5, 0);
    statusRead("R9");

    // R10 overwrite while full
    strobe(8'hC3);
    strobe(8'h96);
    checkPins("R10");
    portRead("R10");

    // R11 capture coincides with port read
    @(negedge clk); portData = 8'hE1; stbIn = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rdEn = 1; rdSel = 0;
    @(negedge clk); rdEn = 0;
    repeat (2) @(negedge clk); stbIn = 0;
    repeat (4) @(negedge clk);
    mByte = 8'hE1; mFull = 1; mIrqA = mIeA; mIrqB = mIeB;
    checkPins("R11");
    portRead("R11");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0, 1: strobe(DW'($urandom));
        2: portRead("R4 rnd");
        3: command(3'($urandom), 1'($urandom));
        default: statusRead("rnd");
      endcase
      checkPins("R3 R6 R8 rnd");
    end

    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule